// File: doc/BRIEF.md
# Microcoded Nibble Execution Datapath

This block is the 4-bit arithmetic core of a small microcoded controller. A free-running step counter divides every instruction into six subcycles. For each instruction the surrounding sequencer supplies an opcode and a flat control word. Each bit of that control word turns on one operand source. The enabled sources are OR-ed together onto two adder inputs, called P and N, and a carry-in bit can also be set. The block adds P, N and the carry-in. From the result it forms a one-bit condition flag. It can then write one 4-bit word back to an external data memory and, two subcycles later, load the accumulator and/or the index register from the low nibble of the sum.

An internal input bus feeds the operand sources and the memory-write path. The opcode chooses what the bus carries: a constant taken from the opcode, the external 4-bit key inputs, or an inverted one-hot bit mask. The data memory sits outside the block and is addressed by the concatenation of an externally held page index and the index register. A one-bit latch can keep a copy of the condition flag for use by output logic elsewhere.

Top module: `nibble_exec_core`

## Requirements
- R1: `phase_o` counts 0,1,2,3,4,5 and then returns to 0. One instruction occupies exactly one pass through the six values.
- R2: While `rst` is high at a clock edge, the following all clear to zero: accumulator, index register, condition flag, flag latch, memory address, write enable and step counter.
- R3: `op_i`, `uw_i`, `k_i`, `mem_rd_i` and `aux_rd_i` are sampled only at the clock edge that ends subcycle 0. Changes to them later in the instruction have no effect.
- R4: N is the OR of the sources enabled by these `uw_i` bits: bit0 all ones, bit1 accumulator, bit2 inverted accumulator, bit3 input bus, bit4 memory word.
- R5: P is the OR of the sources enabled by these `uw_i` bits: bit5 input bus, bit6 memory word, bit7 index register, bit8 `aux_rd_i`, bit9 inverted `aux_rd_i`. `uw_i` bit10 sets the carry-in.
- R6: The sum is P+N+carry-in, 5 bits wide. At the edge that ends subcycle 4, the accumulator loads the low nibble of the sum when `uw_i` bit17 is set, and the index register loads it when bit18 is set. Otherwise each register holds its value.
- R7: At the edge that ends subcycle 2, the condition flag becomes 1. It is then ANDed with sum bit 4 when `uw_i` bit11 is set, and ANDed with (P != N) when bit12 is set.
- R8: When `uw_i` bit19 is set, the flag latch copies the condition flag at the edge that ends subcycle 4. Otherwise the latch holds.
- R9: The input bus depends on the opcode:
  - opcode[7:3]=00001: the bus carries `k_i`.
  - opcode[7:4]=0011: the bus is all ones except for a single 0 at bit position {op[0],op[1]}.
  - opcode[7:6]=01 or opcode[7:3]=00000: the bus is op[3:0] in reversed bit order.
  - any other opcode: the bus is 0.
- R10: `mem_we_o` is high only during subcycle 3, and only if at least one of `uw_i` bits 13..16 is set.
  - The base data is the old accumulator when bit13 (store) is set. Otherwise it is the input bus when bit14 is set. Otherwise it is the memory word.
  - Bit15 then ORs the complement of the input bus into the data, and bit16 then ANDs the input bus into it.
- R11: At the edge that ends subcycle 4, `mem_addr_o` becomes {`x_i`, new index register}. It stays unchanged at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 8 | Opcode of the current instruction |
| uw_i | input | 20 | Control word, bit meanings per R4-R10 |
| k_i | input | DW | Key inputs |
| x_i | input | XW | Page index, upper part of the memory address |
| mem_rd_i | input | DW | Memory word at `mem_addr_o` |
| aux_rd_i | input | DW | Second memory word |
| mem_addr_o | output | XW+DW | Memory address |
| mem_we_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | DW | Memory write data |
| acc_o | output | DW | Accumulator |
| idx_y_o | output | DW | Index register |
| status_o | output | 1 | Condition flag |
| stlatch_o | output | 1 | Flag latch |
| phase_o | output | 3 | Current subcycle |

## Verification
Each error inside the block becomes visible at the ports within a single instruction. A wrong operand-select bit or a wrong input-bus encoding shows up in `acc_o` or `idx_y_o` within six cycles, as long as the control word loads that register. It also shows up in `status_o` after only three cycles whenever a carry test or compare test is enabled. A write strobe that fires in the wrong subcycle, or write data that was merged wrongly, appears in the memory word that the next instruction reads back. A step counter that slips moves every later result out of its expected cycle, so the per-subcycle check of `phase_o` catches it first.

// File: rtl/nibble_exec_pkg.sv
package nibble_exec_pkg;
  localparam int UW_BITS = 20;
  localparam int OPW     = 8;
  localparam logic [2:0] PH_LAST = 3'd5;

  // control word, LSB = field listed last
  typedef struct packed {
    logic stsl;    // 19 flag latch capture
    logic auty;    // 18 sum -> index
    logic auta;    // 17 sum -> accumulator
    logic rbit;    // 16 clear bit
    logic sbit;    // 15 set bit
    logic ckm;     // 14 bus -> memory
    logic sto;     // 13 accumulator -> memory
    logic tst_ne;  // 12 compare test
    logic tst_c;   // 11 carry test
    logic cin;     // 10 carry in
    logic p_naux;  //  9
    logic p_aux;   //  8
    logic p_y;     //  7
    logic p_mem;   //  6
    logic p_bus;   //  5
    logic n_mem;   //  4
    logic n_bus;   //  3
    logic n_na;    //  2
    logic n_a;     //  1
    logic n_ones;  //  0
  } nibble_uw_t;
endpackage

// File: rtl/nibble_inbus.sv
module nibble_inbus
  import nibble_exec_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  k_i,
  output logic [DW-1:0]  bus_o
);
  localparam int SW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] rev;
  logic [DW-1:0] sel_n;

  for (genvar g = 0; g < DW; g++) begin : g_rev
    assign rev[g] = op_i[DW-1-g];
  end

  for (genvar g = 0; g < DW; g++) begin : g_sel
    assign sel_n[g] = !(rev[DW-1 -: SW] == SW'(g));
  end

  always_comb begin
    if (op_i[7:3] == 5'b00001)
      bus_o = k_i;
    else if (op_i[7:4] == 4'b0011)
      bus_o = sel_n;
    else if (op_i[7:6] == 2'b01 || op_i[7:3] == 5'b00000)
      bus_o = rev;
    else
      bus_o = '0;
  end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
  import nibble_exec_pkg::*;
#(
  parameter int DW = 4
) (
  input  nibble_uw_t     uw_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  y_i,
  input  logic [DW-1:0]  bus_i,
  input  logic [DW-1:0]  mem_i,
  input  logic [DW-1:0]  aux_i,
  input  logic [DW-1:0]  p_q_i,
  input  logic [DW-1:0]  n_q_i,
  input  logic           cin_q_i,
  output logic [DW-1:0]  p_nx_o,
  output logic [DW-1:0]  n_nx_o,
  output logic [DW:0]    sum_o,
  output logic           status_o
);
  always_comb begin
    n_nx_o = '0;
    if (uw_i.n_ones) n_nx_o = n_nx_o | {DW{1'b1}};
    if (uw_i.n_a)    n_nx_o = n_nx_o | acc_i;
    if (uw_i.n_na)   n_nx_o = n_nx_o | ~acc_i;
    if (uw_i.n_bus)  n_nx_o = n_nx_o | bus_i;
    if (uw_i.n_mem)  n_nx_o = n_nx_o | mem_i;
  end

  always_comb begin
    p_nx_o = '0;
    if (uw_i.p_bus)  p_nx_o = p_nx_o | bus_i;
    if (uw_i.p_mem)  p_nx_o = p_nx_o | mem_i;
    if (uw_i.p_y)    p_nx_o = p_nx_o | y_i;
    if (uw_i.p_aux)  p_nx_o = p_nx_o | aux_i;
    if (uw_i.p_naux) p_nx_o = p_nx_o | ~aux_i;
  end

  assign sum_o = {1'b0, p_q_i} + {1'b0, n_q_i} + {{DW{1'b0}}, cin_q_i};

  always_comb begin
    status_o = 1'b1;
    if (uw_i.tst_c)  status_o = status_o & sum_o[DW];
    if (uw_i.tst_ne) status_o = status_o & (p_q_i != n_q_i);
  end
endmodule

// File: rtl/nibble_wmerge.sv
module nibble_wmerge
  import nibble_exec_pkg::*;
#(
  parameter int DW = 4
) (
  input  nibble_uw_t    uw_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] mem_i,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] base;

  always_comb begin
    if (uw_i.sto)      base = acc_i;
    else if (uw_i.ckm) base = bus_i;
    else               base = mem_i;
    wdata_o = base;
    if (uw_i.sbit) wdata_o = wdata_o | ~bus_i;
    if (uw_i.rbit) wdata_o = wdata_o & bus_i;
  end

  assign we_o = uw_i.sto | uw_i.ckm | uw_i.sbit | uw_i.rbit;
endmodule

// File: rtl/nibble_exec_core.sv
module nibble_exec_core
  import nibble_exec_pkg::*;
#(
  parameter int DW = 4,
  parameter int XW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OPW-1:0]       op_i,
  input  logic [UW_BITS-1:0]   uw_i,
  input  logic [DW-1:0]        k_i,
  input  logic [XW-1:0]        x_i,
  input  logic [DW-1:0]        mem_rd_i,
  input  logic [DW-1:0]        aux_rd_i,
  output logic [XW+DW-1:0]     mem_addr_o,
  output logic                 mem_we_o,
  output logic [DW-1:0]        mem_wdata_o,
  output logic [DW-1:0]        acc_o,
  output logic [DW-1:0]        idx_y_o,
  output logic                 status_o,
  output logic                 stlatch_o,
  output logic [2:0]           phase_o
);
  localparam int AW = XW + DW;

  nibble_uw_t    uw_in, uw_q;
  logic [2:0]    ph;
  logic [DW-1:0] bus_nx, bus_q, mem_q, aux_q;
  logic [DW-1:0] p_q, n_q, p_nx, n_nx;
  logic          cin_q;
  logic [DW:0]   sum_nx, sum_q;
  logic          status_nx, status_q;
  logic          we_nx, we_q;
  logic [DW-1:0] wd_nx, wd_q;
  logic [DW-1:0] acc_q, y_q;
  logic          stl_q;
  logic [AW-1:0] addr_q;

  assign uw_in = nibble_uw_t'(uw_i);

  nibble_inbus #(.DW(DW)) u_inbus (
    .op_i (op_i),
    .k_i  (k_i),
    .bus_o(bus_nx)
  );

  nibble_alu #(.DW(DW)) u_alu (
    .uw_i    (uw_q),
    .acc_i   (acc_q),
    .y_i     (y_q),
    .bus_i   (bus_q),
    .mem_i   (mem_q),
    .aux_i   (aux_q),
    .p_q_i   (p_q),
    .n_q_i   (n_q),
    .cin_q_i (cin_q),
    .p_nx_o  (p_nx),
    .n_nx_o  (n_nx),
    .sum_o   (sum_nx),
    .status_o(status_nx)
  );

  nibble_wmerge #(.DW(DW)) u_wmerge (
    .uw_i   (uw_q),
    .acc_i  (acc_q),
    .bus_i  (bus_q),
    .mem_i  (mem_q),
    .we_o   (we_nx),
    .wdata_o(wd_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      uw_q     <= '0;
      bus_q    <= '0;
      mem_q    <= '0;
      aux_q    <= '0;
      p_q      <= '0;
      n_q      <= '0;
      cin_q    <= 1'b0;
      sum_q    <= '0;
      status_q <= 1'b0;
      we_q     <= 1'b0;
      wd_q     <= '0;
      acc_q    <= '0;
      y_q      <= '0;
      stl_q    <= 1'b0;
      addr_q   <= '0;
    end else begin
      ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
      case (ph)
        3'd0: begin
          uw_q  <= uw_in;
          bus_q <= bus_nx;
          mem_q <= mem_rd_i;
          aux_q <= aux_rd_i;
          p_q   <= '0;
          n_q   <= '0;
          cin_q <= 1'b0;
        end
        3'd1: begin
          p_q   <= p_nx;
          n_q   <= n_nx;
          cin_q <= uw_q.cin;
        end
        3'd2: begin
          sum_q    <= sum_nx;
          status_q <= status_nx;
          we_q     <= we_nx;
          wd_q     <= wd_nx;
        end
        3'd3: we_q <= 1'b0;
        3'd4: begin
          if (uw_q.auta) acc_q <= sum_q[DW-1:0];
          if (uw_q.auty) y_q   <= sum_q[DW-1:0];
          if (uw_q.stsl) stl_q <= status_q;
          addr_q <= {x_i, (uw_q.auty ? sum_q[DW-1:0] : y_q)};
        end
        default: ;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_we_o    = we_q;
  assign mem_wdata_o = wd_q;
  assign acc_o       = acc_q;
  assign idx_y_o     = y_q;
  assign status_o    = status_q;
  assign stlatch_o   = stl_q;
  assign phase_o     = ph;

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (ph != PH_LAST) |=> (ph == $past(ph) + 3'd1));

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LAST) |=> (ph == 3'd0));

  assert_we_window_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (ph == 3'd3));

  assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ph != 3'd5 && !$past(rst)) |-> ($stable(acc_q) && $stable(y_q)));

  assert_flag_free_R7: assert property (@(posedge clk) disable iff (rst)
    (ph == 3'd3 && !uw_q.tst_c && !uw_q.tst_ne) |-> status_q);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (ph != 3'd5 && !$past(rst)) |-> $stable(mem_addr_o));
endmodule

// File: tb/nibble_exec_core_tb.sv
module nibble_exec_core_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  op_i = '0;
  logic [19:0] uw_i = '0;
  logic [3:0]  k_i = '0, x_i = '0, aux_rd_i = '0;
  logic [3:0]  mem_rd_i;
  logic [7:0]  mem_addr_o;
  logic        mem_we_o;
  logic [3:0]  mem_wdata_o, acc_o, idx_y_o;
  logic        status_o, stlatch_o;
  logic [2:0]  phase_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  localparam logic [19:0] NONES = 20'h1 << 0,  NA = 20'h1 << 1,  NNA = 20'h1 << 2,
                          NBUS  = 20'h1 << 3,  NMEM = 20'h1 << 4, PBUS = 20'h1 << 5,
                          PMEM  = 20'h1 << 6,  PY = 20'h1 << 7,   PAUX = 20'h1 << 8,
                          PNAUX = 20'h1 << 9,  CIN = 20'h1 << 10, TC = 20'h1 << 11,
                          TNE   = 20'h1 << 12, STO = 20'h1 << 13, CKM = 20'h1 << 14,
                          SBIT  = 20'h1 << 15, RBIT = 20'h1 << 16, AUTA = 20'h1 << 17,
                          AUTY  = 20'h1 << 18, STSL = 20'h1 << 19;

  logic [3:0] ram [256];
  logic [3:0] mA = '0, mY = '0;
  logic       mS = 1'b0, mL = 1'b0;
  logic [7:0] mAddr = '0;

  always #10 clk = ~clk;

  assign mem_rd_i = ram[mem_addr_o];
  always @(posedge clk) if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;

  nibble_exec_core u_dut (
    .clk(clk), .rst(rst), .op_i(op_i), .uw_i(uw_i), .k_i(k_i), .x_i(x_i),
    .mem_rd_i(mem_rd_i), .aux_rd_i(aux_rd_i), .mem_addr_o(mem_addr_o),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .acc_o(acc_o),
    .idx_y_o(idx_y_o), .status_o(status_o), .stlatch_o(stlatch_o),
    .phase_o(phase_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] rev4(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  function automatic logic [3:0] bus_of(input logic [7:0] op, input logic [3:0] k);
    if (op[7:3] == 5'b00001) return k;
    if (op[7:4] == 4'b0011) return ~(4'b0001 << {op[0], op[1]});
    if (op[7:6] == 2'b01 || op[7:3] == 5'b00000) return rev4(op[3:0]);
    return 4'h0;
  endfunction

  // one full instruction: drive at phase 0, scramble inputs afterwards, check
  task automatic run_instr(input logic [7:0] op, input logic [19:0] uw,
                           input logic [3:0] k, input logic [3:0] aux,
                           input logic [3:0] x, input string tag);
    logic [3:0] bus, mem, n, p, wd, base, nA, nY;
    logic [4:0] sum;
    logic st, we;
    logic [7:0] wr_addr;
    bus = bus_of(op, k);
    mem = ram[mAddr];
    wr_addr = mAddr;
    n = '0; p = '0;
    if (uw[0]) n = n | 4'hF;
    if (uw[1]) n = n | mA;
    if (uw[2]) n = n | ~mA;
    if (uw[3]) n = n | bus;
    if (uw[4]) n = n | mem;
    if (uw[5]) p = p | bus;
    if (uw[6]) p = p | mem;
    if (uw[7]) p = p | mY;
    if (uw[8]) p = p | aux;
    if (uw[9]) p = p | ~aux;
    sum = {1'b0, p} + {1'b0, n} + {4'b0, uw[10]};
    st = 1'b1;
    if (uw[11]) st = st & sum[4];
    if (uw[12]) st = st & (p != n);
    base = uw[13] ? mA : (uw[14] ? bus : mem);
    wd = base;
    if (uw[15]) wd = wd | ~bus;
    if (uw[16]) wd = wd & bus;
    we = uw[13] | uw[14] | uw[15] | uw[16];
    nA = uw[17] ? sum[3:0] : mA;
    nY = uw[18] ? sum[3:0] : mY;

    op_i = op; uw_i = uw; k_i = k; aux_rd_i = aux; x_i = x;
    for (int s = 0; s < 6; s++) begin
      @(negedge clk);
      chk("R1 phase", phase_o, (s + 1) % 6);
      if (s == 0) begin
        op_i = ~op; uw_i = ~uw; k_i = ~k; aux_rd_i = ~aux;
      end
      if (s == 2) begin
        chk({"R10 we ", tag}, mem_we_o, we);
        if (we) chk({"R10 wdata ", tag}, mem_wdata_o, wd);
        chk({"R7 status ", tag}, status_o, st);
      end else begin
        chk("R10 we idle", mem_we_o, 1'b0);
      end
    end
    chk({"R10 memory ", tag}, ram[wr_addr], we ? wd : mem);
    mA = nA; mY = nY; mS = st;
    if (uw[19]) mL = st;
    mAddr = {x, nY};
    chk({"R6 acc ", tag}, acc_o, mA);
    chk({"R6 idx ", tag}, idx_y_o, mY);
    chk({"R7 flag ", tag}, status_o, mS);
    chk({"R8 latch ", tag}, stlatch_o, mL);
    chk({"R11 addr ", tag}, mem_addr_o, mAddr);
  endtask

  task automatic test_reset_R2();
    chk("R2 acc", acc_o, 4'h0);
    chk("R2 idx", idx_y_o, 4'h0);
    chk("R2 flag", status_o, 1'b0);
    chk("R2 latch", stlatch_o, 1'b0);
    chk("R2 addr", mem_addr_o, 8'h00);
    chk("R2 we", mem_we_o, 1'b0);
    chk("R2 phase", phase_o, 3'd0);
  endtask

  task automatic test_add_R6();
    run_instr(8'h4C, PBUS | AUTA, 4'h0, 4'h0, 4'h0, "R6 load3");
    run_instr(8'h41, NA | PBUS | CIN | AUTA | TC, 4'h0, 4'h0, 4'h0, "R6 add");
    run_instr(8'h4F, NA | PBUS | AUTY | TC, 4'h0, 4'h0, 4'h2, "R6 carry");
    run_instr(8'h90, NONES, 4'h0, 4'h0, 4'h2, "R6 nowrite");
  endtask

  task automatic test_sources_R4_R5();
    run_instr(8'h43, NNA | PY | AUTA, 4'h0, 4'h0, 4'h2, "R4 nota");
    run_instr(8'h45, NBUS | NMEM | AUTY, 4'h0, 4'h0, 4'h2, "R4 busmem");
    run_instr(8'h40, PAUX | NA | AUTA, 4'h0, 4'h9, 4'h2, "R5 aux");
    run_instr(8'h40, PNAUX | PMEM | AUTA, 4'h0, 4'h9, 4'h3, "R5 naux");
    run_instr(8'h46, PBUS | PY | NMEM | CIN | AUTY, 4'h0, 4'h0, 4'h3, "R5 orp");
  endtask

  task automatic test_flag_R7_R8();
    run_instr(8'h4A, PBUS | NBUS | TNE | STSL, 4'h0, 4'h0, 4'h3, "R7 equal");
    run_instr(8'h4A, PBUS | NA | TNE | STSL, 4'h0, 4'h0, 4'h3, "R7 differ");
    run_instr(8'h48, PBUS | NONES | TC, 4'h0, 4'h0, 4'h3, "R8 hold");
    run_instr(8'h40, NONES | TC | TNE | STSL, 4'h0, 4'h0, 4'h3, "R7 bothtests");
  endtask

  task automatic test_inbus_R9();
    run_instr(8'h08, PBUS | AUTY, 4'h5, 4'h0, 4'h1, "R9 keys");
    run_instr(8'h0B, PBUS | AUTA, 4'hA, 4'h0, 4'h1, "R9 keys2");
    run_instr(8'h31, PBUS | AUTA, 4'h0, 4'h0, 4'h1, "R9 bitsel1");
    run_instr(8'h3E, PBUS | AUTA, 4'h0, 4'h0, 4'h1, "R9 bitsel2");
    run_instr(8'h06, PBUS | AUTA, 4'hF, 4'h0, 4'h1, "R9 low");
    run_instr(8'hC5, PBUS | NBUS | AUTA, 4'hF, 4'h0, 4'h1, "R9 zero");
  endtask

  task automatic test_mem_R10();
    run_instr(8'h47, PBUS | AUTA, 4'h0, 4'h0, 4'h6, "R10 prep");
    run_instr(8'h90, STO, 4'h0, 4'h0, 4'h6, "R10 store");
    run_instr(8'h4C, CKM, 4'h0, 4'h0, 4'h6, "R10 busmem");
    run_instr(8'h32, SBIT, 4'h0, 4'h0, 4'h6, "R10 setbit");
    run_instr(8'h31, RBIT, 4'h0, 4'h0, 4'h6, "R10 clrbit");
    run_instr(8'h4C, STO | CKM, 4'h0, 4'h0, 4'h6, "R10 prio");
    run_instr(8'h40, PMEM | AUTA, 4'h0, 4'h0, 4'h6, "R10 readback");
  endtask

  task automatic test_addr_R11();
    run_instr(8'h45, PBUS | AUTY, 4'h0, 4'h0, 4'hB, "R11 newy");
    run_instr(8'h40, PMEM | AUTA, 4'h0, 4'h0, 4'hC, "R11 newx");
  endtask

  task automatic test_hold_R3();
    // run_instr inverts every sampled input after subcycle 0
    run_instr(8'h08, PBUS | NA | AUTA | STSL | TC, 4'h6, 4'h3, 4'h4, "R3 late change");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 4'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset_R2();
    test_add_R6();
    test_sources_R4_R5();
    test_flag_R7_R8();
    test_inbus_R9();
    test_mem_R10();
    test_addr_R11();
    test_hold_R3();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule